// File: doc/BRIEF.md
# Serial Streaming Dense Layer

This block evaluates one fully connected neural network layer on a word-serial stream. Signed fixed-point activations enter one at a time over a valid/acknowledge handshake. Each accepted activation is multiplied against a column of a constant weight matrix, and the products are added into a bank of wide accumulators, one for each output neuron. When a vector is complete, the bank is rounded, saturated and copied into an output buffer. The buffer sends the results one word per clock over a second valid/acknowledge handshake. The bank then restarts from the bias values, so the next vector accumulates while the previous one drains.

The reuse factor `REUSE` sets how many multipliers are built: `ceil(N_OUT/REUSE)`. Each multiplier serves one output index per phase, and each activation is held for `REUSE` phases. Weights and biases are constants computed at elaboration from fixed formulas.

The accumulate side runs three named states:
- `MAC_TAKE` (acknowledge high, phase 0 applied to the arriving word) goes to `MAC_HOLD` when `REUSE>1`. With `REUSE=1` it goes to `MAC_HANDOFF` after the last element.
- `MAC_HOLD` (phases 1..REUSE-1 on the held word) goes back to `MAC_TAKE` after its last phase, or to `MAC_HANDOFF` after the last phase of the last element.
- `MAC_HANDOFF` waits until the buffer is free, copies the bank, reloads the biases and returns to `MAC_TAKE`.

The output side has two states:
- `OB_EMPTY` goes to `OB_SEND` on a copy.
- `OB_SEND` goes back to `OB_EMPTY` on the acknowledged transfer of the last word.

Top module: `dense_serial_layer`

## Requirements
- R1: Input and output data are 18-bit two's complement words with `FRAC`=8 fraction bits. A word moves only on a clock edge where its valid and acknowledge are both high.
- R2: While and after a synchronous reset, `out_valid` is low and `in_ack` is high, until the first complete vector is ready.
- R3: After an input transfer, `in_ack` stays low for `REUSE-1` cycles. With input valid held high, successive elements of a vector are therefore accepted exactly `REUSE` cycles apart.
- R4: Output j (for j from 0 to N_OUT-1) is `sat(round(B_j*2^FRAC + sum_i x_i*W_ij) / 2^FRAC)`. Here `W_ij = (((5i+3j) mod 17) - 8)*32` and `B_j = (((11j) mod 9) - 4)*64` are raw 18-bit words. Outputs are sent in order j = 0 first.
- R5: Results beyond the 18-bit range are clamped to 131071 or -131072.
- R6: Rounding adds 2^(FRAC-1) before an arithmetic right shift by FRAC, so halves round toward plus infinity.
- R7: Once `out_valid` rises, it stays high for exactly N_OUT transfers. With `out_ack` held high, one word leaves per clock.
- R8: While `out_valid` is high and `out_ack` is low, both `out_valid` and `out_data` hold on the next cycle.
- R9: Elements of the next vector are accepted while the previous result is still being sent.
- R10: When a vector has finished accumulating and the buffer still holds an undelivered result, `in_ack` stays low until the buffer empties.
- R11: Each vector starts from the bias values, so the same input vector sent twice gives the same outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input word valid |
| in_data | input | 18 | Input activation |
| in_ack | output | 1 | Block ready to take an input word |
| out_valid | output | 1 | Output word valid |
| out_data | output | 18 | Output result |
| out_ack | input | 1 | Receiver takes the output word |

## Verification
The bench drives inputs to the rails on purpose. A block that wraps instead of clamping would return values of the wrong sign on those vectors. A vector is chosen so that the fraction lands on exactly one half; truncation would then come out one lower.

The bench holds the receiver off across two vectors. A block that overwrote an undrained buffer would lose the first result, and a block that kept acknowledging would accept a word it cannot place. Sending the same vector twice catches a bank that is not reset to the biases. Timing the gaps between acceptances and between output words catches a reuse phase count that is off by one, and catches an output side that inserts idle cycles.

// File: rtl/dense_pkg.sv
package dense_pkg;

    // Raw 18-bit weight linking input i to output j (Q.FRAC)
    function automatic int weight_raw(input int i, input int j);
        return (((i * 5 + j * 3) % 17) - 8) * 32;
    endfunction

    // Raw 18-bit bias of output j (Q.FRAC)
    function automatic int bias_raw(input int j);
        return (((j * 11) % 9) - 4) * 64;
    endfunction

    typedef enum logic [1:0] {
        MAC_TAKE,
        MAC_HOLD,
        MAC_HANDOFF
    } mac_state_t;

    typedef enum logic {
        OB_EMPTY,
        OB_SEND
    } ob_state_t;

endpackage

// File: rtl/dense_mac_bank.sv
module dense_mac_bank
    import dense_pkg::*;
#(
    parameter int N_IN  = 4,
    parameter int N_OUT = 6,
    parameter int REUSE = 2,
    parameter int DW    = 18,
    parameter int FRAC  = 8,
    parameter int AW    = 42
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [DW-1:0]        in_data,
    output logic                 in_ack,
    input  logic                 buf_free,
    output logic                 load_pulse,
    output logic signed [AW-1:0] acc_q [N_OUT]
);

    localparam int NMUL = (N_OUT + REUSE - 1) / REUSE;
    localparam int EW   = (N_IN > 1) ? $clog2(N_IN) : 1;
    localparam int PW   = (REUSE > 1) ? $clog2(REUSE) : 1;

    mac_state_t st_q, st_nx;

    logic [EW-1:0]        elem_q;
    logic [PW-1:0]        phase_q;
    logic signed [DW-1:0] held_q;
    logic signed [DW-1:0] x_op;
    logic [PW-1:0]        ph_op;
    logic                 mac_en;
    logic                 last_elem;
    logic                 last_phase;
    logic signed [2*DW-1:0] prod [NMUL];

    assign last_elem  = (elem_q == EW'(N_IN - 1));
    assign last_phase = (phase_q == PW'(REUSE - 1));

    // State register
    always_ff @(posedge clk) begin
        if (rst) st_q <= MAC_TAKE;
        else     st_q <= st_nx;
    end

    // Next state and outputs
    always_comb begin
        st_nx      = st_q;
        in_ack     = 1'b0;
        mac_en     = 1'b0;
        load_pulse = 1'b0;
        x_op       = held_q;
        ph_op      = phase_q;
        unique case (st_q)
            MAC_TAKE: begin
                in_ack = 1'b1;
                x_op   = $signed(in_data);
                ph_op  = '0;
                mac_en = in_valid;
                if (in_valid) begin
                    if (REUSE > 1)      st_nx = MAC_HOLD;
                    else if (last_elem) st_nx = MAC_HANDOFF;
                end
            end
            MAC_HOLD: begin
                mac_en = 1'b1;
                if (last_phase) st_nx = last_elem ? MAC_HANDOFF : MAC_TAKE;
            end
            MAC_HANDOFF: begin
                load_pulse = buf_free;
                if (buf_free) st_nx = MAC_TAKE;
            end
            default: st_nx = MAC_TAKE;
        endcase
    end

    // Element and phase counters, held operand
    always_ff @(posedge clk) begin
        if (rst) begin
            elem_q  <= '0;
            phase_q <= '0;
            held_q  <= '0;
        end else begin
            unique case (st_q)
                MAC_TAKE: begin
                    if (in_valid) begin
                        held_q <= $signed(in_data);
                        if (REUSE > 1) phase_q <= PW'(1);
                        else           elem_q  <= last_elem ? '0 : elem_q + 1'b1;
                    end
                end
                MAC_HOLD: begin
                    if (last_phase) begin
                        phase_q <= '0;
                        elem_q  <= last_elem ? '0 : elem_q + 1'b1;
                    end else begin
                        phase_q <= phase_q + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // Multiplier slice m serves output p*NMUL+m in phase p
    for (genvar m = 0; m < NMUL; m++) begin : g_mul
        logic signed [DW-1:0] w_sel;
        always_comb begin
            w_sel = '0;
            for (int p = 0; p < REUSE; p++) begin
                for (int i = 0; i < N_IN; i++) begin
                    if ((p * NMUL + m) < N_OUT && ph_op == PW'(p) && elem_q == EW'(i))
                        w_sel = DW'(weight_raw(i, p * NMUL + m));
                end
            end
            prod[m] = x_op * w_sel;
        end
    end

    // Accumulator bank
    always_ff @(posedge clk) begin
        if (rst || load_pulse) begin
            for (int j = 0; j < N_OUT; j++)
                acc_q[j] <= AW'(bias_raw(j)) <<< FRAC;
        end else if (mac_en) begin
            for (int j = 0; j < N_OUT; j++)
                if (ph_op == PW'(j / NMUL))
                    acc_q[j] <= acc_q[j] + AW'(prod[j % NMUL]);
        end
    end

endmodule

// File: rtl/dense_out_buf.sv
module dense_out_buf
    import dense_pkg::*;
#(
    parameter int N_OUT = 6,
    parameter int DW    = 18,
    parameter int FRAC  = 8,
    parameter int AW    = 42
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 load,
    input  logic signed [AW-1:0] acc_i [N_OUT],
    output logic                 buf_free,
    output logic                 out_valid,
    output logic [DW-1:0]        out_data,
    input  logic                 out_ack
);

    localparam int IW = (N_OUT > 1) ? $clog2(N_OUT) : 1;
    localparam logic signed [AW-1:0] RND_ADD = AW'(1) <<< (FRAC - 1);
    localparam logic signed [AW-1:0] SAT_HI  = AW'((1 <<< (DW - 1)) - 1);
    localparam logic signed [AW-1:0] SAT_LO  = AW'(-(1 <<< (DW - 1)));

    ob_state_t st_q, st_nx;

    logic [DW-1:0] obuf_q [N_OUT];
    logic [IW-1:0] idx_q;
    logic          last_idx;
    logic          xfer;

    function automatic logic [DW-1:0] round_sat(input logic signed [AW-1:0] a);
        logic signed [AW-1:0] r;
        r = (a + RND_ADD) >>> FRAC;
        if (r > SAT_HI)      r = SAT_HI;
        else if (r < SAT_LO) r = SAT_LO;
        return r[DW-1:0];
    endfunction

    assign last_idx = (idx_q == IW'(N_OUT - 1));
    assign xfer     = out_valid && out_ack;

    // State register
    always_ff @(posedge clk) begin
        if (rst) st_q <= OB_EMPTY;
        else     st_q <= st_nx;
    end

    // Next state and outputs
    always_comb begin
        st_nx     = st_q;
        buf_free  = 1'b0;
        out_valid = 1'b0;
        unique case (st_q)
            OB_EMPTY: begin
                buf_free = 1'b1;
                if (load) st_nx = OB_SEND;
            end
            OB_SEND: begin
                out_valid = 1'b1;
                if (out_ack && last_idx) st_nx = OB_EMPTY;
            end
            default: st_nx = OB_EMPTY;
        endcase
    end

    assign out_data = obuf_q[idx_q];

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q <= '0;
            for (int j = 0; j < N_OUT; j++) obuf_q[j] <= '0;
        end else if (load) begin
            idx_q <= '0;
            for (int j = 0; j < N_OUT; j++) obuf_q[j] <= round_sat(acc_i[j]);
        end else if (xfer) begin
            idx_q <= last_idx ? '0 : idx_q + 1'b1;
        end
    end

endmodule

// File: rtl/dense_serial_layer.sv
module dense_serial_layer #(
    parameter int N_IN  = 4,
    parameter int N_OUT = 6,
    parameter int REUSE = 2,
    parameter int DW    = 18,
    parameter int FRAC  = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [DW-1:0] in_data,
    output logic          in_ack,
    output logic          out_valid,
    output logic [DW-1:0] out_data,
    input  logic          out_ack
);

    localparam int AW = 2 * DW + $clog2(N_IN + 1) + 2;

    logic                 buf_free;
    logic                 load_pulse;
    logic signed [AW-1:0] acc [N_OUT];

    dense_mac_bank #(
        .N_IN (N_IN),
        .N_OUT(N_OUT),
        .REUSE(REUSE),
        .DW   (DW),
        .FRAC (FRAC),
        .AW   (AW)
    ) u_mac (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_ack    (in_ack),
        .buf_free  (buf_free),
        .load_pulse(load_pulse),
        .acc_q     (acc)
    );

    dense_out_buf #(
        .N_OUT(N_OUT),
        .DW   (DW),
        .FRAC (FRAC),
        .AW   (AW)
    ) u_obuf (
        .clk      (clk),
        .rst      (rst),
        .load     (load_pulse),
        .acc_i    (acc),
        .buf_free (buf_free),
        .out_valid(out_valid),
        .out_data (out_data),
        .out_ack  (out_ack)
    );

endmodule

// File: rtl/dense_serial_layer_chk.sv
module dense_serial_layer_chk #(
    parameter int N_OUT = 6,
    parameter int REUSE = 2,
    parameter int DW    = 18
) (
    input logic          clk,
    input logic          rst,
    input logic          in_valid,
    input logic          in_ack,
    input logic          out_valid,
    input logic [DW-1:0] out_data,
    input logic          out_ack
);

    localparam int CW = $clog2(N_OUT + 1);

    logic [CW-1:0] xfer_q;

    always_ff @(posedge clk) begin
        if (rst) xfer_q <= '0;
        else if (out_valid && out_ack)
            xfer_q <= (xfer_q == CW'(N_OUT - 1)) ? '0 : xfer_q + 1'b1;
    end

    assert_reset_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_valid && in_ack));

    assert_reuse_gap_R3: assert property (@(posedge clk) disable iff (rst)
        (REUSE > 1 && in_valid && in_ack) |=> !in_ack);

    assert_burst_len_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(out_valid) |-> (xfer_q == '0));

    assert_no_gap_R7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ack && xfer_q != CW'(N_OUT - 1)) |=> out_valid);

    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ack) |=> (out_valid && $stable(out_data)));

endmodule

bind dense_serial_layer dense_serial_layer_chk #(
    .N_OUT(N_OUT),
    .REUSE(REUSE),
    .DW   (DW)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_ack   (in_ack),
    .out_valid(out_valid),
    .out_data (out_data),
    .out_ack  (out_ack)
);

// File: tb/test_dense_serial_layer.sv
`timescale 1ns/1ps
module test_dense_serial_layer;

    localparam int N_IN  = 4;
    localparam int N_OUT = 6;
    localparam int REUSE = 2;
    localparam int DW    = 18;
    localparam int FRAC  = 8;
    localparam time CLK  = 20ns;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic          in_ack;
    logic          out_valid;
    logic [DW-1:0] out_data;
    logic          out_ack = 1'b0;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    int sink_mode = 0;    // 0 ready, 1 random, 2 held off
    bit overlap_seen = 0;
    bit done = 0;

    int    exp_q[$];
    string tag_q[$];
    int    acc_cyc[$];
    int    out_cyc[$];

    dense_serial_layer #(
        .N_IN(N_IN), .N_OUT(N_OUT), .REUSE(REUSE), .DW(DW), .FRAC(FRAC)
    ) i_dense_serial_layer (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .in_ack(in_ack), .out_valid(out_valid), .out_data(out_data),
        .out_ack(out_ack)
    );

    always #(CLK/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string tag, input int act, input int exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int w_of(input int i, input int j);
        return (((i * 5 + j * 3) % 17) - 8) * 32;
    endfunction

    function automatic int b_of(input int j);
        return (((j * 11) % 9) - 4) * 64;
    endfunction

    function automatic int ref_out(input int xv[N_IN], input int j);
        longint a;
        a = longint'(b_of(j)) * (longint'(1) << FRAC);
        for (int i = 0; i < N_IN; i++) a += longint'(xv[i]) * w_of(i, j);
        a = (a + (longint'(1) << (FRAC - 1))) >>> FRAC;
        if (a > 131071)  a = 131071;
        if (a < -131072) a = -131072;
        return int'(a);
    endfunction

    // Sink driver
    always @(negedge clk) begin
        if (sink_mode == 0)      out_ack = 1'b1;
        else if (sink_mode == 1) out_ack = ($urandom % 3) != 0;
        else                     out_ack = 1'b0;
    end

    // Monitor, samples at three quarters of the period
    always @(negedge clk) begin
        #(CLK/4);
        if (!rst) begin
            if (in_valid && in_ack) begin
                acc_cyc.push_back(cyc);
                if (out_valid) overlap_seen = 1;
            end
            if (out_valid && out_ack) begin
                out_cyc.push_back(cyc);
                if (exp_q.size() == 0) begin
                    check("R1 unexpected word", int'($signed(out_data)), 0);
                end else begin
                    check(tag_q.pop_front(), int'($signed(out_data)), exp_q.pop_front());
                end
            end
        end
    end

    task automatic send_vec(input int xv[N_IN], input string tag);
        for (int j = 0; j < N_OUT; j++) begin
            exp_q.push_back(ref_out(xv, j));
            tag_q.push_back(tag);
        end
        for (int i = 0; i < N_IN; i++) begin
            in_valid = 1'b1;
            in_data  = DW'(xv[i]);
            while (!in_ack) @(negedge clk);
            @(negedge clk);
        end
        in_valid = 1'b0;
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    function automatic int rnd_word();
        if ($urandom % 4 == 0) return int'($urandom % 64) - 32;
        return int'($urandom % 262144) - 131072;
    endfunction

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int xv[N_IN];
        int held;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        #(CLK/4);
        check("R2 out_valid in reset", int'(out_valid), 0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #(CLK/4);
        check("R2 out_valid after reset", int'(out_valid), 0);
        check("R2 in_ack after reset", int'(in_ack), 1);
        @(negedge clk);

        // R3 spacing and R7 burst on an idle block
        sink_mode = 0;
        xv = '{100, -200, 300, -400};
        acc_cyc.delete();
        out_cyc.delete();
        send_vec(xv, "R4 directed");
        drain();
        for (int k = 1; k < N_IN; k++)
            check("R3 acceptance spacing", acc_cyc[k] - acc_cyc[k-1], REUSE);
        for (int k = 1; k < N_OUT; k++)
            check("R7 output spacing", out_cyc[k] - out_cyc[k-1], 1);

        // R6 exact half
        xv = '{4, 0, 0, 0};
        send_vec(xv, "R6 rounding");
        xv = '{-4, 0, 0, 0};
        send_vec(xv, "R6 rounding neg");
        drain();

        // R5 rails
        xv = '{131071, 131071, 131071, 131071};
        send_vec(xv, "R5 saturation max");
        xv = '{-131072, -131072, -131072, -131072};
        send_vec(xv, "R5 saturation min");
        xv = '{131071, -131072, 131071, -131072};
        send_vec(xv, "R5 saturation mixed");
        drain();

        // R11 same vector twice
        xv = '{777, -1234, 56, 9999};
        send_vec(xv, "R11 repeat first");
        send_vec(xv, "R11 repeat second");
        drain();

        // R10 and R8 with receiver held off
        sink_mode = 2;
        xv = '{1000, 2000, -3000, 4000};
        send_vec(xv, "R10 held vector A");
        xv = '{-50, 60, -70, 80};
        send_vec(xv, "R10 held vector B");
        repeat (2) @(negedge clk);
        #(CLK/4);
        held = int'(out_data);
        repeat (8) @(negedge clk);
        #(CLK/4);
        check("R10 in_ack while buffer full", int'(in_ack), 0);
        check("R8 out_valid held", int'(out_valid), 1);
        check("R8 out_data held", int'(out_data), held);
        @(negedge clk);
        sink_mode = 0;
        drain();

        // R9 back-to-back with ready sink
        overlap_seen = 0;
        for (int v = 0; v < 4; v++) begin
            for (int i = 0; i < N_IN; i++) xv[i] = rnd_word();
            send_vec(xv, "R9 streaming");
        end
        drain();
        check("R9 input accepted during output", int'(overlap_seen), 1);

        // Random with random back-pressure
        sink_mode = 1;
        for (int v = 0; v < 30; v++) begin
            for (int i = 0; i < N_IN; i++) xv[i] = rnd_word();
            send_vec(xv, "R4 random");
            if ($urandom % 4 == 0) repeat ($urandom % 12) @(negedge clk);
        end
        sink_mode = 0;
        drain();
        check("R1 all words delivered", exp_q.size(), 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule